// File: doc/BRIEF.md
# Prescaled Timer with PWM, Output Compare and Input Capture

This block is a 16-bit up-counter with a programmable clock divider in front of it, used as a general timing peripheral. One mode register picks what the counter is for. In PWM mode the counter restarts from zero after it reaches the second compare value, so the period is set by software and the duty cycle by the first compare value. In output-compare mode the counter never restarts early. It runs through all 65536 states, and the output is driven high and low at the two compare values inside that fixed period. In capture mode, a chosen edge on a synchronized input pin records the running count as a timestamp.

Software reaches the block through a simple word-wide register port. Writes take effect at the clock edge. Reads return data one cycle after the request. Status events raise sticky flags that software clears by writing ones. An interrupt line is the OR of the flags that are enabled. Because the capture edge can be switched between two captures without disturbing the counter, the same pin can measure either a full period (same edge twice) or a pulse width (rising edge, then falling edge).

Top module: `cc_timer`

## Requirements
- R1: After reset, every readable register (addresses 0 to 7) reads zero, the wave output is 0 and the interrupt output is 0. Mode 0 (idle) holds the counter.
- R2: The counter advances once every DIV+1 clocks, where DIV is the value at address 1. Right after a mode write, the count is floor(n/(DIV+1)) once n more clocks have passed.
- R3: In PWM mode (mode 1 at address 0), the counter runs from 0 up to R2 (address 3) and then returns to 0. The wave output is registered and is high when the count is below R1 (address 2). With DIV=0, the output is high for min(R1, R2+1) clocks in every R2+1 clocks.
- R4: In compare mode (mode 2), the counter wraps only from 0xFFFF to 0. The wave output goes high on the tick that steps the count onto R1 and low on the tick that steps it onto R2.
- R5: In compare mode with R1 equal to R2, the wave output never changes.
- R6: In capture mode (mode 3), an edge of the selected polarity on cap_in stores the count into the capture register (address 4). The polarity is address 5 bit 0: 0 means rising and 1 means falling. The other edge is ignored. The pin passes through two synchronizing flops, so a change that is driven after clock edge n stores the count as it stands after edge n+2.
- R7: The flags at address 6 are: bit 0 capture, bit 1 step onto R1, bit 2 step onto R2, bit 3 wrap from 0xFFFF, bit 4 capture overrun. They stay set until a write of 1 to the bit clears them. A set and a clear in the same cycle leave the bit set. irq is registered and equals the OR of the flags ANDed with the enable mask at address 7.
- R8: A capture that occurs while the previous capture value has not been read sets the overrun flag, and the newer value replaces the old one. A read of address 4 marks the capture value as read.
- R9: A write to address 0 sets the counter, the divider phase and the wave output to zero in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; data on rdata the next cycle |
| addr | input | 3 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |
| cap_in | input | 1 | Asynchronous capture pin |
| wave_out | output | 1 | Registered PWM / compare output |
| irq | output | 1 | Registered interrupt request |

## Verification
The assertions assume that the mode register changes only through a write, and that such a write always restarts the counter. They also assume that wr_en and rd_en do not both target the flag register at the instant a capture flag is expected. The divider-spacing check assumes that DIV is held steady while a tick is in flight. The stimulus writes DIV and the compare values only before a mode write, keeps cap_in stable for at least six clocks between transitions, and draws the random divider values and pin delays from a small range so that every capture lands well inside one counter period.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    MODE_IDLE = 2'd0,
    MODE_PWM  = 2'd1,
    MODE_CMP  = 2'd2,
    MODE_CAP  = 2'd3
  } tmr_mode_e;

  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_MODE  = 3'd0;
  localparam logic [ADDR_W-1:0] A_DIV   = 3'd1;
  localparam logic [ADDR_W-1:0] A_R1    = 3'd2;
  localparam logic [ADDR_W-1:0] A_R2    = 3'd3;
  localparam logic [ADDR_W-1:0] A_CAPT  = 3'd4;
  localparam logic [ADDR_W-1:0] A_EDGE  = 3'd5;
  localparam logic [ADDR_W-1:0] A_FLAGS = 3'd6;
  localparam logic [ADDR_W-1:0] A_IEN   = 3'd7;

  localparam int NFLAG   = 5;
  localparam int F_CAP   = 0;
  localparam int F_M1    = 1;
  localparam int F_M2    = 2;
  localparam int F_WRAP  = 3;
  localparam int F_OVR   = 4;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] phase_q;

  assign tick = run && !restart && (phase_q >= div);

  always_ff @(posedge clk) begin
    if (rst || restart) phase_q <= '0;
    else if (run)       phase_q <= tick ? '0 : phase_q + 1'b1;
  end

  AST_DIV_SPACING: assert property (@(posedge clk) disable iff (rst)
    (tick && div != '0 && $stable(div)) |=> !tick); // R2
endmodule

// File: rtl/tmr_capture.sv
module tmr_capture #(
  parameter int CNT_W  = 16,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             fall_sel,
  input  logic             pin,
  input  logic [CNT_W-1:0] count,
  output logic             cap_ev,
  output logic [CNT_W-1:0] cap_val
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              pin_s;

  assign pin_s  = sync_q[STAGES-1];
  assign cap_ev = enable && (fall_sel ? (!pin_s && prev_q) : (pin_s && !prev_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q  <= '0;
      prev_q  <= 1'b0;
      cap_val <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin};
      prev_q <= pin_s;
      if (cap_ev) cap_val <= count;
    end
  end

  AST_CAP_STAMP: assert property (@(posedge clk) disable iff (rst)
    cap_ev |=> cap_val == $past(count)); // R6
endmodule

// File: rtl/tmr_wave.sv
module tmr_wave
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  tmr_mode_e        mode,
  input  logic             tick,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] count_nxt,
  input  logic [CNT_W-1:0] r1,
  input  logic [CNT_W-1:0] r2,
  output logic             wave
);
  always_ff @(posedge clk) begin
    if (rst || restart) begin
      wave <= 1'b0;
    end else begin
      unique case (mode)
        MODE_PWM: wave <= (count < r1);
        MODE_CMP: begin
          if (tick && r1 != r2) begin
            if (count_nxt == r1)      wave <= 1'b1;
            else if (count_nxt == r2) wave <= 1'b0;
          end
        end
        default:  wave <= 1'b0;
      endcase
    end
  end

  AST_EQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_CMP && r1 == r2 && !restart) |=> $stable(wave)); // R5
endmodule

// File: rtl/cc_timer.sv
module cc_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DIV_W  = 8,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [2:0]        addr,
  input  logic [CNT_W-1:0]  wdata,
  output logic [CNT_W-1:0]  rdata,
  input  logic              cap_in,
  output logic              wave_out,
  output logic              irq
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  tmr_mode_e        mode_q;
  logic [DIV_W-1:0] div_q;
  logic [CNT_W-1:0] r1_q, r2_q, cnt_q, cnt_nxt, cap_val;
  logic             fall_q, unread_q, tick, cap_ev;
  logic [NFLAG-1:0] flags_q, ien_q, flag_set, flag_clr;
  logic             mode_wr, cap_read;

  assign mode_wr  = wr_en && addr == A_MODE;
  assign cap_read = rd_en && addr == A_CAPT;
  assign cnt_nxt  = (mode_q == MODE_PWM && cnt_q == r2_q) ? '0 : cnt_q + 1'b1;

  tmr_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst(rst), .run(mode_q != MODE_IDLE), .restart(mode_wr),
    .div(div_q), .tick(tick)
  );

  tmr_capture #(.CNT_W(CNT_W), .STAGES(STAGES)) u_cap (
    .clk(clk), .rst(rst), .enable(mode_q == MODE_CAP), .fall_sel(fall_q),
    .pin(cap_in), .count(cnt_q), .cap_ev(cap_ev), .cap_val(cap_val)
  );

  tmr_wave #(.CNT_W(CNT_W)) u_wave (
    .clk(clk), .rst(rst), .restart(mode_wr), .mode(mode_q), .tick(tick),
    .count(cnt_q), .count_nxt(cnt_nxt), .r1(r1_q), .r2(r2_q), .wave(wave_out)
  );

  always_comb begin
    flag_set         = '0;
    flag_set[F_CAP]  = cap_ev;
    flag_set[F_M1]   = tick && cnt_nxt == r1_q;
    flag_set[F_M2]   = tick && cnt_nxt == r2_q;
    flag_set[F_WRAP] = tick && cnt_q == CNT_MAX;
    flag_set[F_OVR]  = cap_ev && unread_q && !cap_read;
    flag_clr         = (wr_en && addr == A_FLAGS) ? wdata[NFLAG-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= MODE_IDLE;
      div_q    <= '0;
      r1_q     <= '0;
      r2_q     <= '0;
      fall_q   <= 1'b0;
      ien_q    <= '0;
      flags_q  <= '0;
      cnt_q    <= '0;
      unread_q <= 1'b0;
      irq      <= 1'b0;
      rdata    <= '0;
    end else begin
      if (wr_en) begin
        unique case (addr)
          A_MODE: mode_q <= tmr_mode_e'(wdata[1:0]);
          A_DIV:  div_q  <= wdata[DIV_W-1:0];
          A_R1:   r1_q   <= wdata;
          A_R2:   r2_q   <= wdata;
          A_EDGE: fall_q <= wdata[0];
          A_IEN:  ien_q  <= wdata[NFLAG-1:0];
          default: ;
        endcase
      end
      if (mode_wr)   cnt_q <= '0;
      else if (tick) cnt_q <= cnt_nxt;
      flags_q <= (flags_q & ~flag_clr) | flag_set;
      if (cap_ev)        unread_q <= 1'b1;
      else if (cap_read) unread_q <= 1'b0;
      irq <= |(flags_q & ien_q);
      if (rd_en) begin
        unique case (addr)
          A_MODE:  rdata <= {{(CNT_W-2){1'b0}}, mode_q};
          A_DIV:   rdata <= {{(CNT_W-DIV_W){1'b0}}, div_q};
          A_R1:    rdata <= r1_q;
          A_R2:    rdata <= r2_q;
          A_CAPT:  rdata <= cap_val;
          A_EDGE:  rdata <= {{(CNT_W-1){1'b0}}, fall_q};
          A_FLAGS: rdata <= {{(CNT_W-NFLAG){1'b0}}, flags_q};
          default: rdata <= {{(CNT_W-NFLAG){1'b0}}, ien_q};
        endcase
      end
    end
  end

  AST_PWM_WRAP: assert property (@(posedge clk) disable iff (rst)
    (tick && mode_q == MODE_PWM && cnt_q == r2_q && !mode_wr) |=> cnt_q == '0); // R3
  AST_CMP_FREE: assert property (@(posedge clk) disable iff (rst)
    (tick && mode_q == MODE_CMP && !mode_wr) |=> cnt_q == $past(cnt_q) + 1'b1); // R4
  AST_RESTART: assert property (@(posedge clk) disable iff (rst)
    mode_wr |=> (cnt_q == '0 && !wave_out)); // R9
  AST_OVERRUN: assert property (@(posedge clk) disable iff (rst)
    (cap_ev && unread_q && !cap_read) |=> flags_q[F_OVR]); // R8
  AST_W1C: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_FLAGS && wdata[F_CAP] && !cap_ev) |=> !flags_q[F_CAP]); // R7
endmodule

// File: tb/cc_timer_bench.sv
`timescale 1ns/1ps
module cc_timer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0, cap_in = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        wave_out, irq;
  int n_chk = 0, n_fail = 0, cyc = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc++;

  cc_timer u_cc_timer (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .cap_in(cap_in), .wave_out(wave_out), .irq(irq)
  );

  function automatic int exp_cap(int n, int p);
    return (n + 2) / (p + 1);
  endfunction

  function automatic int exp_pwm_high(int r1, int r2, int periods);
    return periods * ((r1 < r2 + 1) ? r1 : r2 + 1);
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output int d);
    rd_en = 1'b1; addr = a;
    @(posedge clk);
    @(negedge clk);
    rd_en = 1'b0;
    d = int'(rdata);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual 150000 cycles expected completion sooner");
    finish_run();
  end

  initial begin
    int v, v1, v2, base, tr, tf, hi, r1, r2, p, n, seed;
    seed = $urandom(32'h5eed);
    idle(5);
    rst = 1'b0;
    idle(1);

    // R1 reset values
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      chk("R1 reg", v, 0);
    end
    chk("R1 wave", int'(wave_out), 0);
    chk("R1 irq", int'(irq), 0);

    // R2 / R6 / R9: random divider and pin timing, rising edge
    for (int it = 0; it < 8; it++) begin
      p = int'($urandom % 6);
      n = int'($urandom % 30);
      wr(3'd1, 16'(p));
      wr(3'd0, 16'd3);
      idle(n);
      cap_in = 1'b1;
      idle(6);
      rd(3'd4, v);
      chk("R2/R9 capture", v, exp_cap(n, p));
      cap_in = 1'b0;
      idle(6);
      rd(3'd4, v1);
      chk("R6 falling ignored", v1, v);
    end

    // R6 pulse width: rising then falling with edge switch
    wr(3'd1, 16'd0);
    wr(3'd6, 16'h1f);
    wr(3'd0, 16'd3);
    base = cyc;
    idle(5);
    cap_in = 1'b1; tr = cyc;
    idle(6);
    rd(3'd4, v1);
    chk("R6 rise stamp", v1, tr - base + 2);
    wr(3'd5, 16'd1);
    idle(7);
    cap_in = 1'b0; tf = cyc;
    idle(6);
    rd(3'd4, v2);
    chk("R6 width", v2 - v1, tf - tr);
    wr(3'd5, 16'd0);

    // R8 overrun
    wr(3'd6, 16'h1f);
    wr(3'd0, 16'd3);
    base = cyc;
    idle(4);
    cap_in = 1'b1;
    idle(6);
    cap_in = 1'b0;
    idle(6);
    cap_in = 1'b1; tr = cyc;
    idle(6);
    rd(3'd6, v);
    chk("R8 overrun flag", v & 32'h11, 32'h11);
    rd(3'd4, v);
    chk("R8 newest value", v, tr - base + 2);
    cap_in = 1'b0;
    idle(6);

    // R7 masking, irq, write-one-to-clear
    chk("R7 masked irq", int'(irq), 0);
    wr(3'd7, 16'h01);
    idle(1);
    chk("R7 irq set", int'(irq), 1);
    wr(3'd6, 16'h1f);
    idle(1);
    chk("R7 irq clear", int'(irq), 0);
    rd(3'd6, v);
    chk("R7 flags clear", v, 0);
    wr(3'd7, 16'h00);

    // R4 compare window
    wr(3'd2, 16'd10);
    wr(3'd3, 16'd20);
    wr(3'd0, 16'd2);
    for (int i = 1; i <= 30; i++) begin
      idle(1);
      chk("R4 compare level", int'(wave_out), (i >= 10 && i < 20) ? 1 : 0);
    end
    rd(3'd6, v);
    chk("R4/R7 match flags", v & 6, 6);

    // R5 equal compare values
    wr(3'd2, 16'd15);
    wr(3'd3, 16'd15);
    wr(3'd0, 16'd2);
    hi = 0;
    for (int i = 0; i < 40; i++) begin
      idle(1);
      hi += int'(wave_out);
    end
    chk("R5 no toggle", hi, 0);

    // R3 random PWM duty
    for (int it = 0; it < 5; it++) begin
      r2 = 3 + int'($urandom % 18);
      r1 = int'($urandom % (r2 + 4));
      wr(3'd2, 16'(r1));
      wr(3'd3, 16'(r2));
      wr(3'd0, 16'd1);
      idle(3);
      hi = 0;
      for (int j = 0; j < 4 * (r2 + 1); j++) begin
        idle(1);
        hi += int'(wave_out);
      end
      chk("R3 duty", hi, exp_pwm_high(r1, r2, 4));
    end

    // R4 full-period wrap in compare mode
    wr(3'd2, 16'd0);
    wr(3'd3, 16'd0);
    wr(3'd6, 16'h1f);
    wr(3'd0, 16'd2);
    idle(65535);
    rd(3'd6, v);
    chk("R4 no early wrap", v & 8, 0);
    rd(3'd6, v);
    chk("R4/R7 wrap flag", v & 8, 8);

    finish_run();
  end
endmodule